// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the bus-side configuration front end of a multifunction peripheral chip. It sits behind two byte-wide I/O locations. Offset 0 is the index port and offset 1 is the data port. The index port also carries the key bytes that open and close configuration access. Configuration stays closed until the enter key is written to the index port on two index writes in a row. A separate leave key closes it again. Both key bytes are fixed at build time. A parameter chooses between the primary pair (0x87 / 0xAA) and an alternate pair (0x88 / 0xBB) for a companion device.

While the port is open, the byte written to the index port selects a configuration register, and the data port reads or writes that register. Three registers are global: a logical-device selector, a read-only chip identifier, and an activate register. Every logical device has its own bank: one activate bit plus a short run of general storage bytes. The device selector routes activate and bank accesses to the chosen device. Each device's activate bit leaves the block as an output. By convention the watchdog function is logical device 8.

The controller has three states. **LOCKED** is the reset state. **ARMED** means one enter key has been seen. **OPEN** means registers are reachable. It has four transitions:
- LOCKED→ARMED on an enter-key index write.
- ARMED→OPEN on a second enter-key index write.
- ARMED→LOCKED on any other index write.
- OPEN→LOCKED on a leave-key index write.

Read data is registered. It appears on the cycle after the read strobe and holds until the next read.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset, `cfg_unlocked` is 0, `rdata` is 0xFF, every `dev_active` bit is 0, and both the device selector and the index hold 0x00.
- R2: Two index writes (`port_addr`=0) of the enter key (0x87 by default) with no other index write between them open the port. `cfg_unlocked` goes to 1 in the cycle after the second write.
- R3: While the port is not open, an index write of any byte other than the enter key returns the controller to LOCKED. The next two enter keys are then needed to open it.
- R4: While the port is not open, data-port writes change nothing, and reads of either port return 0xFF.
- R5: In OPEN, an index write of the leave key (0xAA by default) returns to LOCKED and does not change the latched index.
- R6: In OPEN, every other index write, including the enter key, is latched as the index. The index is kept across data accesses and across lock/unlock, and reading the index port returns it.
- R7: Register 0x07 holds the selected logical device and reads back as written. The 0xF0–0xF7 storage bytes belong to the selected device only.
- R8: Register 0x20 reads the chip identifier (default 0xC6). Writes to it are ignored.
- R9: Register 0x30 bit 0 is the activate bit of the selected device. It drives `dev_active[device]`, and bits 7:1 read as 0.
- R10: With a selector value of NUM_DEV (10) or more, registers 0x30 and 0xF0–0xF7 read 0xFF and ignore writes. Registers outside 0x07, 0x20, 0x30 and 0xF0–0xF7 read 0x00 and ignore writes.
- R11: `rdata` changes only in the cycle after a cycle with `rd_en`=1, and holds otherwise.
- R12: Data-port accesses made in ARMED neither complete nor break the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| cfg_unlocked | output | 1 | High while configuration access is open |
| dev_active | output | NUM_DEV | Activate bit of each logical device |

## Verification
The assertions assume the bus never raises `rd_en` and `wr_en` in the same cycle, and one of them checks this at the inputs. The unlock, leave and read-back properties rely on it. The bench drives every access as a single-strobe cycle followed by an idle cycle, so this rule holds by construction. The stimulus still covers mixed index and data traffic between the two keys, the enter key written while open, and selector values beyond the device count.

// File: rtl/kcp_pkg.sv
package kcp_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } kcp_state_e;

    // Global configuration register indexes
    localparam logic [7:0] REG_DEVSEL   = 8'h07;
    localparam logic [7:0] REG_CHIPID   = 8'h20;
    localparam logic [7:0] REG_ACTIVATE = 8'h30;
    localparam logic [7:0] BANK_BASE    = 8'hF0;

    // Key pairs: primary and companion-device alternate
    localparam logic [7:0] KEY_ENTER_PRI = 8'h87;
    localparam logic [7:0] KEY_LEAVE_PRI = 8'hAA;
    localparam logic [7:0] KEY_ENTER_ALT = 8'h88;
    localparam logic [7:0] KEY_LEAVE_ALT = 8'hBB;

    localparam logic [7:0] READ_ABSENT   = 8'hFF;

endpackage

// File: rtl/kcp_unlock_fsm.sv
module kcp_unlock_fsm
    import kcp_pkg::*;
#(
    parameter logic [7:0] ENTER_KEY = KEY_ENTER_PRI,
    parameter logic [7:0] LEAVE_KEY = KEY_LEAVE_PRI
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic       idx_load
);

    kcp_state_e state_q;
    kcp_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: only index-port writes move the machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (idx_wr && (wdata == ENTER_KEY)) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (idx_wr) begin
                    state_d = (wdata == ENTER_KEY) ? ST_OPEN : ST_LOCKED;
                end
            end
            ST_OPEN: begin
                if (idx_wr && (wdata == LEAVE_KEY)) begin
                    state_d = ST_LOCKED;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        unlocked = (state_q == ST_OPEN);
        idx_load = (state_q == ST_OPEN) && idx_wr && (wdata != LEAVE_KEY);
    end

endmodule

// File: rtl/kcp_index_latch.sv
module kcp_index_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_load,
    input  logic       sel_wr,
    input  logic [7:0] wdata,
    output logic [7:0] idx_q,
    output logic [7:0] sel_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (idx_load) begin
            idx_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 8'h00;
        end else if (sel_wr) begin
            sel_q <= wdata;
        end
    end

endmodule

// File: rtl/kcp_dev_bank.sv
module kcp_dev_bank
    import kcp_pkg::*;
#(
    parameter int BANK_REGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic       active,
    output logic [7:0] rd_byte
);

    localparam int OFFW = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;

    logic [7:0]      mem_q [BANK_REGS];
    logic            in_bank;
    logic [OFFW-1:0] off;

    always_comb begin
        in_bank = ({1'b0, idx} >= {1'b0, BANK_BASE}) &&
                  ({1'b0, idx} < ({1'b0, BANK_BASE} + 9'(BANK_REGS)));
        off     = idx[OFFW-1:0] - BANK_BASE[OFFW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (wr_hit && (idx == REG_ACTIVATE)) begin
            active <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BANK_REGS; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else if (wr_hit && in_bank) begin
            mem_q[off] <= wdata;
        end
    end

    always_comb begin
        if (idx == REG_ACTIVATE) begin
            rd_byte = {7'b0, active};
        end else if (in_bank) begin
            rd_byte = mem_q[off];
        end else begin
            rd_byte = 8'h00;
        end
    end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import kcp_pkg::*;
#(
    parameter bit         ALT_KEYS  = 1'b0,
    parameter int         NUM_DEV   = 10,
    parameter int         BANK_REGS = 8,
    parameter logic [7:0] CHIP_ID   = 8'hC6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic               cfg_unlocked,
    output logic [NUM_DEV-1:0] dev_active
);

    localparam logic [7:0] ENTER_KEY = ALT_KEYS ? KEY_ENTER_ALT : KEY_ENTER_PRI;
    localparam logic [7:0] LEAVE_KEY = ALT_KEYS ? KEY_LEAVE_ALT : KEY_LEAVE_PRI;

    logic             idx_wr;
    logic             idx_load;
    logic             data_wr;
    logic             sel_wr;
    logic [7:0]       idx_q;
    logic [7:0]       sel_q;
    logic             sel_valid;
    logic             idx_is_bank;
    logic [7:0]       sel_rd;
    logic [7:0]       rd_val;
    logic [7:0]       bank_rd [NUM_DEV];

    // Constant views for the bound checker
    logic [7:0]       enter_key;
    logic [7:0]       leave_key;
    logic [7:0]       id_byte;
    assign enter_key = ENTER_KEY;
    assign leave_key = LEAVE_KEY;
    assign id_byte   = CHIP_ID;

    assign idx_wr  = wr_en && !port_addr;
    assign data_wr = wr_en && port_addr && cfg_unlocked;
    assign sel_wr  = data_wr && (idx_q == REG_DEVSEL);

    kcp_unlock_fsm #(
        .ENTER_KEY (ENTER_KEY),
        .LEAVE_KEY (LEAVE_KEY)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (wdata),
        .unlocked (cfg_unlocked),
        .idx_load (idx_load)
    );

    kcp_index_latch u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_load (idx_load),
        .sel_wr   (sel_wr),
        .wdata    (wdata),
        .idx_q    (idx_q),
        .sel_q    (sel_q)
    );

    assign sel_valid   = ({1'b0, sel_q} < 9'(NUM_DEV));
    assign idx_is_bank = (idx_q == REG_ACTIVATE) ||
                         (({1'b0, idx_q} >= {1'b0, BANK_BASE}) &&
                          ({1'b0, idx_q} < ({1'b0, BANK_BASE} + 9'(BANK_REGS))));

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic hit;
        assign hit = data_wr && (sel_q == 8'(d));

        kcp_dev_bank #(
            .BANK_REGS (BANK_REGS)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (hit),
            .idx     (idx_q),
            .wdata   (wdata),
            .active  (dev_active[d]),
            .rd_byte (bank_rd[d])
        );
    end

    // Selected bank read data
    always_comb begin
        sel_rd = READ_ABSENT;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (sel_q == 8'(d)) begin
                sel_rd = bank_rd[d];
            end
        end
    end

    // Read routing
    always_comb begin
        if (!cfg_unlocked) begin
            rd_val = READ_ABSENT;
        end else if (!port_addr) begin
            rd_val = idx_q;
        end else if (idx_q == REG_DEVSEL) begin
            rd_val = sel_q;
        end else if (idx_q == REG_CHIPID) begin
            rd_val = CHIP_ID;
        end else if (idx_is_bank) begin
            rd_val = sel_valid ? sel_rd : READ_ABSENT;
        end else begin
            rd_val = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= READ_ABSENT;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
    parameter int NUM_DEV = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               port_addr,
    input logic               wr_en,
    input logic               rd_en,
    input logic [7:0]         wdata,
    input logic [7:0]         rdata,
    input logic               cfg_unlocked,
    input logic [NUM_DEV-1:0] dev_active,
    input logic [7:0]         idx_q,
    input logic [7:0]         enter_key,
    input logic [7:0]         leave_key,
    input logic [7:0]         id_byte
);

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R11

    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_unlocked) |-> $past(wr_en && !port_addr && wdata == enter_key)); // R2

    AST_BAD_KEY_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_unlocked && wr_en && !port_addr && wdata != enter_key) |=> !cfg_unlocked); // R3

    AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_unlocked && rd_en) |=> (rdata == 8'hFF)); // R4

    AST_LOCKED_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |=> $stable(dev_active)); // R4

    AST_LEAVE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && wr_en && !port_addr && wdata == leave_key) |=> !cfg_unlocked); // R5

    AST_LEAVE_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && wr_en && !port_addr && wdata == leave_key) |=> $stable(idx_q)); // R5

    AST_CHIPID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && rd_en && port_addr && idx_q == 8'h20) |=> (rdata == id_byte)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R11

endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_addr    (port_addr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .wdata        (wdata),
    .rdata        (rdata),
    .cfg_unlocked (cfg_unlocked),
    .dev_active   (dev_active),
    .idx_q        (idx_q),
    .enter_key    (enter_key),
    .leave_key    (leave_key),
    .id_byte      (id_byte)
);

// File: tb/keyed_cfg_port_test.sv
`timescale 1ns/1ps
module keyed_cfg_port_test;

    localparam int ND = 10;
    localparam int BR = 8;
    localparam int CID = 8'hC6;
    localparam logic [7:0] KE = 8'h87;
    localparam logic [7:0] KL = 8'hAA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          port_addr = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic          cfg_unlocked;
    logic [ND-1:0] dev_active;

    always #2.5 clk = ~clk;

    keyed_cfg_port uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_addr    (port_addr),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .wdata        (wdata),
        .rdata        (rdata),
        .cfg_unlocked (cfg_unlocked),
        .dev_active   (dev_active)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Behavioural reference model: 0 locked, 1 one key seen, 2 open
    int m_state;
    int m_idx;
    int m_sel;
    int m_rd;
    int m_bank [ND][BR];
    bit m_act [ND];

    function automatic int model_read(bit a);
        if (m_state != 2) return 8'hFF;
        if (!a) return m_idx;
        if (m_idx == 8'h07) return m_sel;
        if (m_idx == 8'h20) return CID;
        if (m_idx == 8'h30) return (m_sel < ND) ? int'(m_act[m_sel]) : 8'hFF;
        if (m_idx >= 8'hF0 && m_idx < 8'hF0 + BR)
            return (m_sel < ND) ? m_bank[m_sel][m_idx - 8'hF0] : 8'hFF;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_idx = 0; m_sel = 0; m_rd = 8'hFF;
            for (int d = 0; d < ND; d++) begin
                m_act[d] = 1'b0;
                for (int r = 0; r < BR; r++) m_bank[d][r] = 0;
            end
        end else begin
            if (rd_en) m_rd = model_read(port_addr);
            if (wr_en && !port_addr) begin
                case (m_state)
                    0: m_state = (wdata == KE) ? 1 : 0;
                    1: m_state = (wdata == KE) ? 2 : 0;
                    default: if (wdata == KL) m_state = 0; else m_idx = wdata;
                endcase
            end else if (wr_en && port_addr && m_state == 2) begin
                if (m_idx == 8'h07) m_sel = wdata;
                else if (m_idx == 8'h30 && m_sel < ND) m_act[m_sel] = wdata[0];
                else if (m_idx >= 8'hF0 && m_idx < 8'hF0 + BR && m_sel < ND)
                    m_bank[m_sel][m_idx - 8'hF0] = wdata;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #2;
        if (!done) begin
            logic [ND-1:0] exp_act;
            for (int d = 0; d < ND; d++) exp_act[d] = m_act[d];
            n_cmp++;
            if (rdata !== 8'(m_rd) || cfg_unlocked !== (m_state == 2) || dev_active !== exp_act) begin
                n_bad++;
                $display("FAIL %s: rdata=%02h unlocked=%0b act=%b expected rdata=%02h unlocked=%0b act=%b",
                         cur_req, rdata, cfg_unlocked, dev_active, 8'(m_rd), (m_state == 2), exp_act);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic op(input bit a, input bit w, input bit r, input logic [7:0] d);
        @(negedge clk);
        port_addr = a; wr_en = w; rd_en = r; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr_idx(input logic [7:0] d); op(1'b0, 1'b1, 1'b0, d); endtask
    task automatic wr_dat(input logic [7:0] d); op(1'b1, 1'b1, 1'b0, d); endtask
    task automatic rd_chk(input bit a, input int exp, input string tag);
        op(a, 1'b0, 1'b1, 8'h00);
        chk(tag, int'(rdata), exp);
    endtask
    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d); wr_idx(i); wr_dat(d); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        chk("R1 rdata", int'(rdata), 8'hFF);
        chk("R1 unlocked", int'(cfg_unlocked), 0);
        chk("R1 active", int'(dev_active), 0);

        cur_req = "R4";
        wr_dat(8'h12);
        rd_chk(1'b1, 8'hFF, "R4 data read locked");
        rd_chk(1'b0, 8'hFF, "R4 index read locked");

        cur_req = "R3";
        wr_idx(KE); wr_idx(8'h55); wr_idx(KE);
        chk("R3 broken sequence stays locked", int'(cfg_unlocked), 0);
        wr_idx(KE);
        chk("R3 restart then opens", int'(cfg_unlocked), 1);
        wr_idx(KL);

        cur_req = "R12";
        wr_idx(KE);
        rd_chk(1'b1, 8'hFF, "R12 data read while armed");
        wr_dat(8'h33);
        wr_idx(KE);
        chk("R12 opens after data traffic", int'(cfg_unlocked), 1);

        cur_req = "R2";
        chk("R2 unlocked", int'(cfg_unlocked), 1);

        cur_req = "R6";
        wr_idx(8'h30);
        rd_chk(1'b0, 8'h30, "R6 index readback");
        wr_idx(KE);
        rd_chk(1'b0, 8'h87, "R6 enter key latched while open");

        cur_req = "R7";
        reg_wr(8'h07, 8'h08);
        rd_chk(1'b1, 8'h08, "R7 selector readback");
        reg_wr(8'hF0, 8'h5C);
        reg_wr(8'h07, 8'h02);
        reg_wr(8'hF0, 8'h11);
        rd_chk(1'b1, 8'h11, "R7 device 2 byte");
        reg_wr(8'h07, 8'h08);
        wr_idx(8'hF0);
        rd_chk(1'b1, 8'h5C, "R7 device 8 byte kept");

        cur_req = "R9";
        reg_wr(8'h30, 8'hFF);
        rd_chk(1'b1, 8'h01, "R9 activate readback");
        chk("R9 dev_active", int'(dev_active), 10'h100);

        cur_req = "R8";
        wr_idx(8'h20);
        rd_chk(1'b1, 8'hC6, "R8 chip id");
        wr_dat(8'h00);
        rd_chk(1'b1, 8'hC6, "R8 chip id after write");

        cur_req = "R10";
        reg_wr(8'h07, 8'h0C);
        reg_wr(8'hF0, 8'h77);
        rd_chk(1'b1, 8'hFF, "R10 absent bank byte");
        reg_wr(8'h30, 8'h01);
        rd_chk(1'b1, 8'hFF, "R10 absent activate");
        chk("R10 no activate", int'(dev_active), 10'h100);
        reg_wr(8'h55, 8'h9A);
        rd_chk(1'b1, 8'h00, "R10 unmapped register");
        reg_wr(8'h07, 8'h09);
        reg_wr(8'hF7, 8'h42);
        rd_chk(1'b1, 8'h42, "R10 last device last byte");

        cur_req = "R6";
        reg_wr(8'hF1, 8'hA5);
        rd_chk(1'b1, 8'hA5, "R6 index kept over data access");
        wr_dat(8'hA6);
        rd_chk(1'b1, 8'hA6, "R6 read-modify-write one index");

        cur_req = "R11";
        repeat (4) @(negedge clk);
        chk("R11 rdata held", int'(rdata), 8'hA6);

        cur_req = "R5";
        wr_idx(KL);
        chk("R5 locked after leave", int'(cfg_unlocked), 0);
        rd_chk(1'b0, 8'hFF, "R5 index hidden");
        wr_idx(KE); wr_idx(KE);
        rd_chk(1'b0, 8'hF1, "R5 leave key not latched");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule